// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps a 32-bit effective address to a physical address through a small set of block translation entries. Each entry is a pair of 32-bit words, an upper word and a lower word. The unit keeps two independent sets of entries. Instruction fetches look up the instruction set. Loads and stores look up the data set. A write port loads any word of any entry.

A request carries an effective address, an access kind and a privilege flag. Every entry of the selected set is checked at the same time for validity, for a match under a variable block-length mask, and for its access rights. The lowest-numbered entry that is both valid and matching decides the outcome. One cycle later the unit reports one of three results: a hit with its permissions and physical address, a protection fault, or a miss.

A static input selects between two register encodings. The two encodings place the block length, the validity and the protection bits differently. The address compare and the physical address composition are the same in both.

Top module: `bat_xlate`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` into the entry chosen by `cfg_idx`. `cfg_iside` selects the instruction set (1) or the data set (0), and `cfg_upper` selects the upper word (1) or the lower word (0). The new value is used by requests from the next cycle on.
- R2: `req_kind` 2'b00 is a load and 2'b01 is a store; both use the data set. 2'b10 and 2'b11 are instruction fetches and use the instruction set.
- R3: In the standard encoding (`alt_enc`=0), an entry is valid when upper bit 1 is set for a supervisor request, or when upper bit 0 is set for a user request (`req_user`=1). The length mask is upper bits 12:2 and applies to address bits 27:17. The entry matches when address bits 31:28 equal upper bits 31:28 and when address bits 27:17, with the mask bits cleared, equal upper bits 27:17.
- R4: The physical address has three parts. Bits 31:28 are lower bits 31:28. Bits 27:17 are (address bits 27:17 AND mask) OR lower bits 27:17. Bits 16:0 are the address bits 16:0.
- R5: In the standard encoding, the protection field is lower bits 1:0. Value 0 grants nothing, value 2 grants read, write and execute, and values 1 and 3 grant read and execute.
- R6: In the alternate encoding (`alt_enc`=1), the mask is lower bits 5:0 and applies to address bits 22:17. The valid bit is lower bit 6. The protection field is upper bits 1:0. The key is upper bit 3 for supervisor requests and upper bit 2 for user requests. With key 0, field value 3 grants read and execute and every other value grants all three rights. With key 1, value 0 grants nothing, value 2 grants all three, and values 1 and 3 grant read and execute.
- R7: When several entries are valid and match, the lowest index decides the result. An entry that matches but is not valid for the request is skipped.
- R8: A load needs read, a store needs write and a fetch needs execute. When the deciding entry grants the needed right, `rsp_hit` goes high. When it does not, `rsp_fault` goes high instead. In both cases `rsp_perm` ({x,w,r}) and `rsp_pa` show that entry. On a miss, hit, fault, permissions and address are all zero.
- R9: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. The response fields hold their values while no request is made.
- R10: Reset clears every entry of both sets and deasserts `rsp_valid`, `rsp_hit` and `rsp_fault`. A request after reset with no writes is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_iside | input | 1 | Write target: 1 instruction set, 0 data set |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_upper | input | 1 | Write target word: 1 upper, 0 lower |
| cfg_wdata | input | 32 | Word to store |
| alt_enc | input | 1 | Register encoding select: 0 standard, 1 alternate |
| req_valid | input | 1 | Lookup request strobe |
| req_kind | input | 2 | Access kind: load, store or fetch |
| req_user | input | 1 | 1 for user privilege, 0 for supervisor |
| req_ea | input | 32 | Effective address |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | Translation granted |
| rsp_fault | output | 1 | Valid match whose rights forbid the access |
| rsp_perm | output | 3 | Rights of the deciding entry, {x,w,r} |
| rsp_pa | output | 32 | Physical address |

## Verification
The case that is hardest to reach from the ports is a request matched by several entries at once, where lower-numbered ones are skipped because they are invalid for the current privilege and a later one decides. The random phase draws the top address nibble of every entry from only four values and keeps the length masks sparse, so address overlaps between entries are common. Each effective address is built from the compare bits of a randomly chosen entry, with the masked bits and the offset randomised. Directed cases add a fixed three-entry overlap, alternate-encoding key splits, and fetch against load on entries with the same address.

// File: rtl/bat_pkg.sv
package bat_pkg;

   localparam int unsigned WORD_W = 32;

   typedef enum logic [1:0] {
      KIND_LOAD  = 2'b00,
      KIND_STORE = 2'b01,
      KIND_FETCH = 2'b10,
      KIND_FETCH2 = 2'b11
   } bat_kind_e;

   typedef struct packed {
      logic x;
      logic w;
      logic r;
   } bat_perm_t;

   typedef struct packed {
      logic              sel;
      bat_perm_t         perm;
      logic [WORD_W-1:0] pa;
   } bat_res_t;

   // standard encoding: 0 none, 2 full, 1/3 read+exec
   function automatic bat_perm_t perm_std(input logic [1:0] pp);
      bat_perm_t p;
      p.r = (pp != 2'd0);
      p.x = (pp != 2'd0);
      p.w = (pp == 2'd2);
      return p;
   endfunction

   // alternate encoding: key selects the rights table
   function automatic bat_perm_t perm_alt(input logic key, input logic [1:0] pp);
      bat_perm_t p;
      if (!key) begin
         p.r = 1'b1;
         p.x = 1'b1;
         p.w = (pp != 2'd3);
      end else begin
         p.r = (pp != 2'd0);
         p.x = (pp != 2'd0);
         p.w = (pp == 2'd2);
      end
      return p;
   endfunction

endpackage

// File: rtl/bat_regfile.sv
module bat_regfile #(
   parameter int unsigned NUM_ENTRIES = 4,
   parameter int unsigned IDX_W       = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic                               wr_side,
   input  logic [IDX_W-1:0]                   wr_idx,
   input  logic                               wr_hi,
   input  logic [31:0]                        wr_data,
   input  logic                               rd_side,
   output logic [NUM_ENTRIES-1:0][31:0]       rd_up,
   output logic [NUM_ENTRIES-1:0][31:0]       rd_lo
);

   logic [1:0][NUM_ENTRIES-1:0][31:0] up_q;
   logic [1:0][NUM_ENTRIES-1:0][31:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q <= '0;
         lo_q <= '0;
      end else if (wr_en) begin
         for (int e = 0; e < int'(NUM_ENTRIES); e++) begin
            if (wr_idx == IDX_W'(e)) begin
               if (wr_hi) up_q[wr_side][e] <= wr_data;
               else       lo_q[wr_side][e] <= wr_data;
            end
         end
      end
   end

   assign rd_up = up_q[rd_side];
   assign rd_lo = lo_q[rd_side];

endmodule

// File: rtl/bat_entry_eval.sv
module bat_entry_eval
   import bat_pkg::*;
#(
   parameter bit ALT_EN = 1'b1
) (
   input  logic [31:0] up,
   input  logic [31:0] lo,
   input  logic        alt_mode,
   input  logic        user,
   input  logic [31:0] ea,
   output bat_res_t    res
);

   logic [10:0] mask_std, mask_alt, mask;
   logic        vld_std, vld_alt, vld;
   bat_perm_t   perm_s, perm_a;
   logic        match;

   assign mask_std = up[12:2];
   assign vld_std  = user ? up[0] : up[1];
   assign perm_s   = perm_std(lo[1:0]);

   generate
      if (ALT_EN) begin : g_alt
         assign mask_alt = {5'b0, lo[5:0]};
         assign vld_alt  = lo[6];
         assign perm_a   = perm_alt(user ? up[2] : up[3], up[1:0]);
      end else begin : g_no_alt
         assign mask_alt = '0;
         assign vld_alt  = 1'b0;
         assign perm_a   = '0;
      end
   endgenerate

   assign mask  = alt_mode ? mask_alt : mask_std;
   assign vld   = alt_mode ? vld_alt  : vld_std;
   assign match = (ea[31:28] == up[31:28]) &&
                  ((ea[27:17] & ~mask) == up[27:17]);

   always_comb begin
      res.sel  = vld & match;
      res.perm = alt_mode ? perm_a : perm_s;
      res.pa   = {lo[31:28], (ea[27:17] & mask) | lo[27:17], ea[16:0]};
   end

endmodule

// File: rtl/bat_first_pick.sv
module bat_first_pick
   import bat_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 4
) (
   input  bat_res_t [NUM_ENTRIES-1:0] cand,
   output bat_res_t                   win
);

   always_comb begin
      win = '0;
      for (int i = int'(NUM_ENTRIES) - 1; i >= 0; i--) begin
         if (cand[i].sel) win = cand[i];
      end
   end

endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
   import bat_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 4,
   parameter bit          ALT_EN      = 1'b1,
   localparam int unsigned IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_iside,
   input  logic [IDX_W-1:0] cfg_idx,
   input  logic             cfg_upper,
   input  logic [31:0]      cfg_wdata,
   input  logic             alt_enc,
   input  logic             req_valid,
   input  logic [1:0]       req_kind,
   input  logic             req_user,
   input  logic [31:0]      req_ea,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic             rsp_fault,
   output logic [2:0]       rsp_perm,
   output logic [31:0]      rsp_pa
);

   generate
      if (NUM_ENTRIES < 1 || NUM_ENTRIES > 32) begin : g_bad_entries
         $error("bat_xlate: NUM_ENTRIES must lie in 1..32");
      end
   endgenerate

   logic [NUM_ENTRIES-1:0][31:0] sel_up, sel_lo;
   bat_res_t [NUM_ENTRIES-1:0]   cand;
   bat_res_t                     win;
   logic                         need_ok;
   logic                         hit_d, fault_d;

   bat_regfile #(
      .NUM_ENTRIES(NUM_ENTRIES),
      .IDX_W      (IDX_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we),
      .wr_side(cfg_iside),
      .wr_idx (cfg_idx),
      .wr_hi  (cfg_upper),
      .wr_data(cfg_wdata),
      .rd_side(req_kind[1]),
      .rd_up  (sel_up),
      .rd_lo  (sel_lo)
   );

   generate
      for (genvar g = 0; g < int'(NUM_ENTRIES); g++) begin : g_ent
         bat_entry_eval #(.ALT_EN(ALT_EN)) u_eval (
            .up      (sel_up[g]),
            .lo      (sel_lo[g]),
            .alt_mode(alt_enc),
            .user    (req_user),
            .ea      (req_ea),
            .res     (cand[g])
         );
      end
   endgenerate

   bat_first_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
      .cand(cand),
      .win (win)
   );

   always_comb begin
      unique case (bat_kind_e'(req_kind))
         KIND_LOAD:  need_ok = win.perm.r;
         KIND_STORE: need_ok = win.perm.w;
         default:    need_ok = win.perm.x;
      endcase
   end

   assign hit_d   = win.sel &  need_ok;
   assign fault_d = win.sel & ~need_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_perm  <= '0;
         rsp_pa    <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_hit   <= hit_d;
            rsp_fault <= fault_d;
            rsp_perm  <= win.sel ? win.perm : 3'b000;
            rsp_pa    <= win.sel ? win.pa   : 32'h0;
         end
      end
   end

endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [1:0]  req_kind,
   input logic [31:0] req_ea,
   input logic        rsp_valid,
   input logic        rsp_hit,
   input logic        rsp_fault,
   input logic [2:0]  rsp_perm,
   input logic [31:0] rsp_pa
);

   p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_rsp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(rsp_pa) && $stable(rsp_hit) && $stable(rsp_fault)));

   p_hit_fault_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_hit && rsp_fault));

   p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit && !rsp_fault) |-> (rsp_pa == 32'h0 && rsp_perm == 3'b000));

   p_hit_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |->
         ($past(req_kind[1]) ? rsp_perm[2] : ($past(req_kind[0]) ? rsp_perm[1] : rsp_perm[0])));

   p_fault_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |->
         !($past(req_kind[1]) ? rsp_perm[2] : ($past(req_kind[0]) ? rsp_perm[1] : rsp_perm[0])));

   p_offset_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_hit || rsp_fault)) |-> (rsp_pa[16:0] == $past(req_ea[16:0])));

endmodule

bind bat_xlate bat_xlate_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_kind (req_kind),
   .req_ea   (req_ea),
   .rsp_valid(rsp_valid),
   .rsp_hit  (rsp_hit),
   .rsp_fault(rsp_fault),
   .rsp_perm (rsp_perm),
   .rsp_pa   (rsp_pa)
);

// File: tb/bat_xlate_test.sv
module bat_xlate_test;

   localparam int CLK_P = 10;
   localparam int N     = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_iside = 1'b0, cfg_upper = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic        alt_enc = 1'b0;
   logic        req_valid = 1'b0, req_user = 1'b0;
   logic [1:0]  req_kind = '0;
   logic [31:0] req_ea = '0;
   logic        rsp_valid, rsp_hit, rsp_fault;
   logic [2:0]  rsp_perm;
   logic [31:0] rsp_pa;

   int n_tests = 0;
   int n_fail  = 0;
   logic [31:0] sh_up [2][N];
   logic [31:0] sh_lo [2][N];

   always #(CLK_P/2) clk = ~clk;

   bat_xlate #(.NUM_ENTRIES(N)) uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_iside(cfg_iside), .cfg_idx(cfg_idx),
      .cfg_upper(cfg_upper), .cfg_wdata(cfg_wdata), .alt_enc(alt_enc),
      .req_valid(req_valid), .req_kind(req_kind), .req_user(req_user),
      .req_ea(req_ea), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_fault(rsp_fault), .rsp_perm(rsp_perm), .rsp_pa(rsp_pa)
   );

   function automatic logic [10:0] mask_of(input logic [31:0] up, input logic [31:0] lo,
                                           input logic alt);
      return alt ? {5'b0, lo[5:0]} : up[12:2];
   endfunction

   // expected {hit, fault, perm{x,w,r}, pa}
   function automatic logic [36:0] model(input logic [31:0] ea, input logic [1:0] kind,
                                         input logic user, input logic alt);
      logic s;
      s = kind[1];
      for (int i = 0; i < N; i++) begin
         logic [31:0] u, l;
         logic [10:0] m;
         logic v, key, need;
         logic [1:0] pp;
         logic [2:0] pr;
         u = sh_up[s][i];
         l = sh_lo[s][i];
         m = mask_of(u, l, alt);
         v = alt ? l[6] : (user ? u[0] : u[1]);
         if (v && ea[31:28] == u[31:28] && ((ea[27:17] & ~m) == u[27:17])) begin
            if (!alt) begin
               pp = l[1:0];
               pr = (pp == 2'd0) ? 3'b000 : (pp == 2'd2) ? 3'b111 : 3'b101;
            end else begin
               pp  = u[1:0];
               key = user ? u[2] : u[3];
               if (!key) pr = (pp == 2'd3) ? 3'b101 : 3'b111;
               else      pr = (pp == 2'd0) ? 3'b000 : (pp == 2'd2) ? 3'b111 : 3'b101;
            end
            need = kind[1] ? pr[2] : (kind[0] ? pr[1] : pr[0]);
            return {need, ~need, pr, l[31:28], (ea[27:17] & m) | l[27:17], ea[16:0]};
         end
      end
      return '0;
   endfunction

   task automatic chk(input string tag, input logic [36:0] act, input logic [36:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic side, input int idx, input logic hi, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_iside = side; cfg_idx = 2'(idx); cfg_upper = hi; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (hi) sh_up[side][idx] = d;
      else    sh_lo[side][idx] = d;
   endtask

   task automatic ent(input logic side, input int idx, input logic [31:0] u, input logic [31:0] l);
      wr(side, idx, 1'b1, u);
      wr(side, idx, 1'b0, l);
   endtask

   task automatic rq(input logic [31:0] ea, input logic [1:0] kind, input logic user);
      @(negedge clk);
      req_valid = 1'b1; req_ea = ea; req_kind = kind; req_user = user;
      @(negedge clk);
      req_valid = 1'b0;
      n_tests++;
      if (rsp_valid !== 1'b1) begin
         n_fail++;
         $display("FAIL R9: rsp_valid actual=%b expected=1", rsp_valid);
      end
   endtask

   function automatic logic [36:0] got();
      return {rsp_hit, rsp_fault, rsp_perm, rsp_pa};
   endfunction

   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [36:0] hold;
      void'($urandom(32'd4711));
      for (int s = 0; s < 2; s++)
         for (int i = 0; i < N; i++) begin sh_up[s][i] = '0; sh_lo[s][i] = '0; end

      repeat (3) @(negedge clk);
      chk("R10 reset outputs", {rsp_valid, rsp_hit, rsp_fault, 34'h0}, 37'h0);
      rst_n = 1'b1;
      rq(32'h3001_2345, 2'b00, 1'b0);
      chk("R10 empty entries miss", got(), 37'h0);

      // standard encoding basic hit and privilege split
      ent(1'b0, 0, 32'h3000_0002, 32'h8000_0002);
      rq(32'h3001_2345, 2'b00, 1'b0);
      chk("R1/R3 supervisor load hit", got(), {2'b10, 3'b111, 32'h8001_2345});
      rq(32'h3001_2345, 2'b00, 1'b1);
      chk("R3 user invalid miss", got(), 37'h0);

      // protection decoding
      wr(1'b0, 0, 1'b0, 32'h8000_0001);
      rq(32'h3001_2345, 2'b01, 1'b0);
      chk("R5/R8 store read-only faults", got(), {2'b01, 3'b101, 32'h8001_2345});
      rq(32'h3001_2345, 2'b00, 1'b0);
      chk("R5 load read-only hits", got(), {2'b10, 3'b101, 32'h8001_2345});
      wr(1'b0, 0, 1'b0, 32'h8000_0000);
      rq(32'h3001_2345, 2'b00, 1'b0);
      chk("R5 no-access faults", got(), {2'b01, 3'b000, 32'h8001_2345});

      // full length mask
      ent(1'b0, 1, 32'h5000_1FFF, 32'h9000_0002);
      rq(32'h5ABC_DEF0, 2'b00, 1'b1);
      chk("R3/R4 full mask user hit", got(), {2'b10, 3'b111, 32'h9ABC_DEF0});

      // priority across overlapping entries
      ent(1'b0, 0, 32'h6000_0002, 32'h1000_0002);
      ent(1'b0, 1, 32'h6000_0001, 32'h2000_0002);
      ent(1'b0, 2, 32'h6000_0003, 32'h3000_0002);
      rq(32'h6000_0100, 2'b00, 1'b1);
      chk("R7 skip invalid first entry", got(), {2'b10, 3'b111, 32'h2000_0100});
      rq(32'h6000_0100, 2'b00, 1'b0);
      chk("R7 lowest index wins", got(), {2'b10, 3'b111, 32'h1000_0100});

      // instruction set selected by fetch
      ent(1'b1, 3, 32'h6000_0003, 32'h4000_0002);
      rq(32'h6000_0100, 2'b10, 1'b0);
      chk("R2 fetch uses instruction set", got(), {2'b10, 3'b111, 32'h4000_0100});
      rq(32'h6000_0100, 2'b11, 1'b1);
      chk("R2 fetch kind 3", got(), {2'b10, 3'b111, 32'h4000_0100});
      hold = got();
      @(negedge clk);
      chk("R9 idle holds", {rsp_valid, got()}, {1'b0, hold});

      // alternate encoding
      alt_enc = 1'b1;
      ent(1'b0, 3, 32'h7000_0004, 32'hA000_007F);
      rq(32'h707E_1234, 2'b00, 1'b0);
      chk("R6 alt supervisor key0 full", got(), {2'b10, 3'b111, 32'hA07E_1234});
      rq(32'h707E_1234, 2'b00, 1'b1);
      chk("R6 alt user key1 none faults", got(), {2'b01, 3'b000, 32'hA07E_1234});
      rq(32'h6000_0100, 2'b00, 1'b0);
      chk("R6 alt ignores standard valid bits", got(), 37'h0);

      // constrained random
      for (int round = 0; round < 60; round++) begin
         alt_enc = $urandom % 2;
         for (int s = 0; s < 2; s++)
            for (int i = 0; i < N; i++) begin
               logic [31:0] u, l;
               logic [10:0] m;
               u = $urandom;
               l = $urandom;
               u[31:28] = {2'b00, 2'($urandom)};
               u[12:2]  = 11'($urandom & $urandom & $urandom);
               l[5:0]   = 6'($urandom & $urandom);
               m = mask_of(u, l, alt_enc);
               u[27:17] = u[27:17] & ~m;
               ent(s[0], i, u, l);
            end
         for (int k = 0; k < 12; k++) begin
            logic [31:0] ea, u, l;
            logic [1:0]  kd;
            logic        us;
            int          pick;
            pick = $urandom % N;
            kd   = 2'($urandom);
            us   = 1'($urandom);
            u    = sh_up[kd[1]][pick];
            l    = sh_lo[kd[1]][pick];
            ea   = $urandom;
            if (($urandom % 5) != 0)
               ea = {u[31:28], u[27:17] | (ea[27:17] & mask_of(u, l, alt_enc)), ea[16:0]};
            rq(ea, kd, us);
            chk("R3/R4/R5/R6/R7/R8 random", got(), model(ea, kd, us, alt_enc));
         end
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule